// File: doc/BRIEF.md
# Picture-Bus Nametable Mirroring Controller

This block sits on the 14-bit address bus of a picture processor. The same bus reaches pattern memory and a 4 KiB nametable RAM. For each access the block works out which device is selected and which address the nametable RAM sees. Three arrangements are supported. In four-screen mode all four 1 KiB nametables are distinct. In vertical mode address bit 11 is dropped, so the lower pair of nametables repeats the upper pair. In horizontal mode address bit 10 is dropped, so the left and right nametables of each pair are the same.

The arrangement comes from one of two places. It can be latched from a cartridge-style configuration byte when a load strobe is pulsed, or it can be forced by a hard-wired strap. Any address bit that is dropped is driven to logic 0, never left floating. Dropping an address bit applies only to nametable-range accesses, so pattern memory always sees its true address lines. All address and select outputs are combinational from the current bus address and the selected mode, with no added latency.

Top module: `nt_mirror_ctrl`

## Requirements
- R1: An access (read or write strobe high) with address below 0x2000 raises `pat_sel`, keeps `ram_cs` low, and drives `pat_addr` equal to address bits 12:0, in every mode.
- R2: An access in 0x2000..0x3EFF raises `ram_cs` and keeps `pat_sel` low. The range 0x3000..0x3EFF maps to the same RAM address as the address 0x1000 lower. Addresses 0x3F00..0x3FFF raise neither select.
- R3: With both `ppu_rd` and `ppu_wr` low, neither `ram_cs` nor `pat_sel` is raised.
- R4: In four-screen mode, `ram_addr` equals address bits 11:0.
- R5: In vertical mode, `ram_addr` is {1'b0, address bits 10:0} for nametable accesses, so 0x2800..0x2FFF alias 0x2000..0x27FF.
- R6: In horizontal mode, `ram_addr` is {address bit 11, 1'b0, address bits 9:0}, so 0x2400 aliases 0x2000 and 0x2C00 aliases 0x2800.
- R7: Configuration byte decoding: if bit 3 is set the mode is four-screen, whatever bit 0 is. Otherwise, if bit 0 is set the mode is vertical. Otherwise it is horizontal. Examples: 0x21 gives vertical, 0x28 gives four-screen, 0x29 gives four-screen, 0x00 gives horizontal.
- R8: The mode is latched from `cfg_byte` on a rising clock edge where `cfg_load` is high. It holds while `cfg_load` is low, whatever `cfg_byte` does. Reset (`rst_n` low) selects four-screen.
- R9: While `strap_sel` is high, the mode follows `strap_mode` (0 four-screen, 1 vertical, 2 horizontal, 3 four-screen) and the latched mode is ignored. When `strap_sel` falls, the latched mode is in force again, unchanged.
- R10: The outputs respond to a change of address or strobe in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the mode latch |
| rst_n | input | 1 | Asynchronous active-low reset |
| ppu_addr | input | 14 | Picture-processor address bus |
| ppu_rd | input | 1 | Read strobe |
| ppu_wr | input | 1 | Write strobe |
| cfg_byte | input | 8 | Configuration byte carrying the mirroring bits |
| cfg_load | input | 1 | Latch `cfg_byte` on this clock edge |
| strap_sel | input | 1 | Use the hard-wired strap instead of the latched mode |
| strap_mode | input | 2 | Strap mirroring code |
| ram_addr | output | 12 | Nametable RAM address |
| ram_cs | output | 1 | Nametable RAM select |
| pat_sel | output | 1 | Pattern memory select |
| pat_addr | output | 13 | Pattern memory address, unmodified |

## Verification
On every cycle, the assertions check the following. Pattern and nametable selects are never high together, and an idle bus raises neither. Each mode forces its dropped bit to zero on nametable accesses while pattern memory keeps the raw address. The latched mode never changes without a load strobe. Only the bench's scenarios can show the rest: that the configuration-byte priority picks the right mode, that specific aliased address pairs land on the same RAM word, that the strap takes over and then hands back the preserved latched mode, and that reset leaves the block in four-screen mode.

// File: rtl/nt_mirror_pkg.sv
package nt_mirror_pkg;

  typedef enum logic [1:0] {
    MIR_FOUR = 2'd0,
    MIR_VERT = 2'd1,
    MIR_HORZ = 2'd2
  } mirror_e;

  // Decode a configuration byte; the four-screen bit outranks the vertical bit.
  function automatic mirror_e cfg_to_mode(input logic [7:0] b, input int four_bit,
                                          input int vert_bit);
    logic four_req;
    logic vert_req;
    four_req = 1'b0;
    vert_req = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i == four_bit) four_req = b[i];
      if (i == vert_bit) vert_req = b[i];
    end
    if (four_req)      return MIR_FOUR;
    else if (vert_req) return MIR_VERT;
    else               return MIR_HORZ;
  endfunction

  function automatic mirror_e strap_to_mode(input logic [1:0] s);
    case (s)
      2'd1:    return MIR_VERT;
      2'd2:    return MIR_HORZ;
      default: return MIR_FOUR;
    endcase
  endfunction

  // Effective nametable address: dropped bits are forced to 0.
  // Vertical uses A11 AND NOT A13 so pattern-range addresses keep A11.
  function automatic logic [11:0] remap_addr(input logic [13:0] a, input mirror_e m);
    logic [11:0] r;
    r = a[11:0];
    case (m)
      MIR_VERT: r[11] = a[11] & ~a[13];
      MIR_HORZ: r[10] = 1'b0;
      default:  r = a[11:0];
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mirror_mode_sel.sv
module mirror_mode_sel
  import nt_mirror_pkg::*;
#(
  parameter int CFG_W    = 8,
  parameter int FOUR_BIT = 3,
  parameter int VERT_BIT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_byte,
  input  logic             cfg_load,
  input  logic             strap_sel,
  input  logic [1:0]       strap_mode,
  output mirror_e          mode_o
);

  mirror_e latched_q;
  mirror_e cfg_mode;
  mirror_e strap_m;

  assign cfg_mode = cfg_to_mode(cfg_byte[7:0], FOUR_BIT, VERT_BIT);
  assign strap_m  = strap_to_mode(strap_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latched_q <= MIR_FOUR;
    else if (cfg_load) latched_q <= cfg_mode;
  end

  assign mode_o = strap_sel ? strap_m : latched_q;

  // R8: latched mode only moves on a load strobe
  a_r8_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(latched_q));

  // R9: the strap never disturbs the latched mode
  a_r9_strap_keeps_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_sel && !cfg_load) |=> $stable(latched_q));

endmodule

// File: rtl/ppu_region_dec.sv
module ppu_region_dec #(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output logic              pat_hit,
  output logic              nt_hit
);

  localparam int NT_BIT = ADDR_W - 1;

  logic access;
  logic palette_zone;

  assign access       = rd | wr;
  assign palette_zone = &addr[ADDR_W-1:8];
  assign pat_hit      = access & ~addr[NT_BIT];
  assign nt_hit       = access & addr[NT_BIT] & ~palette_zone;

  // R1/R2: one device at a time
  a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pat_hit, nt_hit}));

  // R3: idle bus selects nothing
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd || wr) |-> (!pat_hit && !nt_hit));

endmodule

// File: rtl/nt_addr_remap.sv
module nt_addr_remap
  import nt_mirror_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int NT_AW  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  mirror_e           mode,
  output logic [NT_AW-1:0]  ram_addr
);

  assign ram_addr = remap_addr(addr, mode);

  // R4: four-screen passes the low bits through
  a_r4_four_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MIR_FOUR) |-> (ram_addr == addr[NT_AW-1:0]));

  // R5: vertical drops A11 for nametable-range addresses only
  a_r5_vert_a11_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MIR_VERT && addr[ADDR_W-1]) |-> (ram_addr[11] == 1'b0 && ram_addr[10:0] == addr[10:0]));

  // R6: horizontal drops A10 and keeps A11
  a_r6_horz_a10_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MIR_HORZ) |-> (ram_addr[10] == 1'b0 && ram_addr[11] == addr[11]));

endmodule

// File: rtl/nt_mirror_ctrl.sv
module nt_mirror_ctrl
  import nt_mirror_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int NT_AW    = 12,
  parameter int CFG_W    = 8,
  parameter int FOUR_BIT = 3,
  parameter int VERT_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ppu_addr,
  input  logic              ppu_rd,
  input  logic              ppu_wr,
  input  logic [CFG_W-1:0]  cfg_byte,
  input  logic              cfg_load,
  input  logic              strap_sel,
  input  logic [1:0]        strap_mode,
  output logic [NT_AW-1:0]  ram_addr,
  output logic              ram_cs,
  output logic              pat_sel,
  output logic [ADDR_W-2:0] pat_addr
);

  mirror_e mode_w;
  logic    pat_hit_w;
  logic    nt_hit_w;

  mirror_mode_sel #(.CFG_W(CFG_W), .FOUR_BIT(FOUR_BIT), .VERT_BIT(VERT_BIT)) u_mode (
    .clk(clk), .rst_n(rst_n), .cfg_byte(cfg_byte), .cfg_load(cfg_load),
    .strap_sel(strap_sel), .strap_mode(strap_mode), .mode_o(mode_w)
  );

  ppu_region_dec #(.ADDR_W(ADDR_W)) u_region (
    .clk(clk), .rst_n(rst_n), .addr(ppu_addr), .rd(ppu_rd), .wr(ppu_wr),
    .pat_hit(pat_hit_w), .nt_hit(nt_hit_w)
  );

  nt_addr_remap #(.ADDR_W(ADDR_W), .NT_AW(NT_AW)) u_remap (
    .clk(clk), .rst_n(rst_n), .addr(ppu_addr), .mode(mode_w), .ram_addr(ram_addr)
  );

  assign ram_cs   = nt_hit_w;
  assign pat_sel  = pat_hit_w;
  assign pat_addr = ppu_addr[ADDR_W-2:0];

  // R1: pattern accesses see raw address lines and never the RAM
  a_r1_pattern_raw: assert property (@(posedge clk) disable iff (!rst_n)
    pat_sel |-> (!ram_cs && pat_addr == ppu_addr[ADDR_W-2:0]));

endmodule

// File: tb/nt_mirror_ctrl_tb.sv
module nt_mirror_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] ppu_addr = '0;
  logic        ppu_rd = 1'b0;
  logic        ppu_wr = 1'b0;
  logic [7:0]  cfg_byte = '0;
  logic        cfg_load = 1'b0;
  logic        strap_sel = 1'b0;
  logic [1:0]  strap_mode = '0;
  logic [11:0] ram_addr;
  logic        ram_cs;
  logic        pat_sel;
  logic [12:0] pat_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  nt_mirror_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ppu_addr(ppu_addr), .ppu_rd(ppu_rd), .ppu_wr(ppu_wr),
    .cfg_byte(cfg_byte), .cfg_load(cfg_load), .strap_sel(strap_sel),
    .strap_mode(strap_mode), .ram_addr(ram_addr), .ram_cs(ram_cs),
    .pat_sel(pat_sel), .pat_addr(pat_addr)
  );

  // {cfg, addr, rd, wr}
  localparam int NV = 14;
  localparam logic [23:0] VEC [NV] = '{
    {8'h28, 14'h2C05, 1'b1, 1'b0},
    {8'h28, 14'h0123, 1'b1, 1'b0},
    {8'h21, 14'h2A17, 1'b1, 1'b0},
    {8'h21, 14'h2217, 1'b0, 1'b1},
    {8'h21, 14'h1ABC, 1'b1, 1'b0},
    {8'h00, 14'h2400, 1'b1, 1'b0},
    {8'h00, 14'h2C3F, 1'b0, 1'b1},
    {8'h00, 14'h0F00, 1'b0, 1'b1},
    {8'h29, 14'h2E01, 1'b1, 1'b0},
    {8'h28, 14'h3C10, 1'b1, 1'b0},
    {8'h21, 14'h3EFF, 1'b1, 1'b0},
    {8'h00, 14'h3F00, 1'b1, 1'b0},
    {8'h21, 14'h2800, 1'b0, 1'b0},
    {8'h01, 14'h2BFF, 1'b1, 1'b0}
  };

  // mode codes: 0 four, 1 vertical, 2 horizontal
  function automatic int exp_mode(input logic [7:0] b);
    if (b[3]) return 0;
    if (b[0]) return 1;
    return 2;
  endfunction

  function automatic logic [11:0] exp_ram(input logic [13:0] a, input int m);
    int off;
    off = int'(a) % 4096;
    if (m == 1) off = off % 2048;
    else if (m == 2) off = (off / 2048) * 2048 + (off % 1024);
    return 12'(off);
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load_cfg(input logic [7:0] b);
    @(negedge clk);
    cfg_byte = b;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic access(input logic [13:0] a, input logic r, input logic w);
    ppu_addr = a; ppu_rd = r; ppu_wr = w;
    #1;
  endtask

  task automatic check_access(input string tag, input logic [13:0] a, input logic r,
                              input logic w, input int m);
    logic act;
    logic e_cs;
    logic e_pat;
    act   = r | w;
    e_pat = act && (a < 14'h2000);
    e_cs  = act && (a >= 14'h2000) && (a < 14'h3F00);
    access(a, r, w);
    chk({tag, " R2/R3 ram_cs"}, 16'(ram_cs), 16'(e_cs));
    chk({tag, " R1/R3 pat_sel"}, 16'(pat_sel), 16'(e_pat));
    if (e_pat) chk({tag, " R1 pat_addr"}, 16'(pat_addr), 16'(a[12:0]));
    if (e_cs) begin
      if (m == 0)      chk({tag, " R4 ram_addr"}, 16'(ram_addr), 16'(exp_ram(a, m)));
      else if (m == 1) chk({tag, " R5 ram_addr"}, 16'(ram_addr), 16'(exp_ram(a, m)));
      else             chk({tag, " R6 ram_addr"}, 16'(ram_addr), 16'(exp_ram(a, m)));
    end
  endtask

  initial begin
    #100000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [11:0] a_lo;
    // R8 reset state: four-screen
    access(14'h2C05, 1'b1, 1'b0);
    chk("R8 reset four-screen", 16'(ram_addr), 16'h0C05);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    access(14'h2A00, 1'b1, 1'b0);
    chk("R8 after reset four-screen", 16'(ram_addr), 16'h0A00);

    // R7 table walk
    for (int i = 0; i < NV; i++) begin
      load_cfg(VEC[i][23:16]);
      check_access($sformatf("R7 vec%0d", i), VEC[i][15:2], VEC[i][1], VEC[i][0],
                   exp_mode(VEC[i][23:16]));
    end

    // R5 aliasing pair under vertical
    load_cfg(8'h21);
    access(14'h2805, 1'b1, 1'b0); a_lo = ram_addr;
    access(14'h2005, 1'b1, 1'b0);
    chk("R5 alias 2805/2005", 16'(a_lo), 16'(ram_addr));
    // R6 aliasing pair under horizontal
    load_cfg(8'h20);
    access(14'h2C33, 1'b1, 1'b0); a_lo = ram_addr;
    access(14'h2833, 1'b1, 1'b0);
    chk("R6 alias 2C33/2833", 16'(a_lo), 16'(ram_addr));
    // R2 mirror region 0x3xxx equals 0x2xxx
    access(14'h3456, 1'b0, 1'b1); a_lo = ram_addr;
    access(14'h2456, 1'b0, 1'b1);
    chk("R2 3456 mirrors 2456", 16'(a_lo), 16'(ram_addr));

    // R8 hold: byte changes without load have no effect (horizontal stays)
    @(negedge clk);
    cfg_byte = 8'h28;
    repeat (2) @(negedge clk);
    access(14'h2400, 1'b1, 1'b0);
    chk("R8 hold without load", 16'(ram_addr), 16'h0000);

    // R9 strap overrides, then hands back latched horizontal
    strap_sel = 1'b1; strap_mode = 2'd1;
    access(14'h2C00, 1'b1, 1'b0);
    chk("R9 strap vertical", 16'(ram_addr), 16'h0400);
    strap_mode = 2'd3;
    access(14'h2C00, 1'b1, 1'b0);
    chk("R9 strap code3 four", 16'(ram_addr), 16'h0C00);
    strap_mode = 2'd2;
    access(14'h2400, 1'b1, 1'b0);
    chk("R9 strap horizontal", 16'(ram_addr), 16'h0000);
    strap_mode = 2'd0;
    repeat (2) @(negedge clk);
    strap_sel = 1'b0;
    access(14'h2C00, 1'b1, 1'b0);
    chk("R9 latched mode restored", 16'(ram_addr), 16'h0800);

    // R10 same-cycle response: change address mid-cycle, no edge between
    @(posedge clk); #2;
    access(14'h0100, 1'b1, 1'b0);
    chk("R10 pat_sel immediate", 16'(pat_sel), 16'h1);
    access(14'h2100, 1'b1, 1'b0);
    chk("R10 ram_cs immediate", 16'(ram_cs), 16'h1);
    access(14'h2100, 1'b0, 1'b0);
    chk("R3 idle immediate", 16'(ram_cs | pat_sel), 16'h0);

    // R8 reset mid-run returns four-screen
    @(negedge clk); rst_n = 1'b0;
    access(14'h2C00, 1'b1, 1'b0);
    chk("R8 reset returns four-screen", 16'(ram_addr), 16'h0C00);
    @(negedge clk); rst_n = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule